// File: doc/BRIEF.md
# Power-Mode Direct Transition Sequencer

This block steps a processor from one run mode to another when a sleep request arrives and the direct-transition controls are set. It knows three run modes: high-speed active, medium-speed active and subactive. A valid request, taken while the block is idle, fixes a target mode from the mode-control inputs. The block then stalls the CPU and counts the sleep and internal-processing states on the clock that drives the present mode. At the switch point it updates the current mode and the clock-select code.

After the switch, the block counts states on the new clock. When the source mode was subactive, it first inserts an oscillator-settling wait whose length comes from a 3-bit select. It then releases the stall and counts the interrupt exception-handling states, after which it gives a single-cycle completion pulse.

Every clock is modelled as a state-rate tick enable inside one synchronous domain. `hs_tick` marks one high-speed system-clock state, `ms_tick` marks one medium-speed state and `sub_tick` marks one subclock state. The real oscillators, the CPU core and the interrupt controller are outside the block.

Top module: `pwr_direct_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the block returns to idle. After that edge `mode_o` = 0 (high-speed), `clk_sel_o` = 0, `cpu_stall_o` = 0 and `done_o` = 0.
- R2: A request is taken only from idle, and only when `ctl_standby`, `ctl_direct` and `ctl_timer3` are all 1. The target mode is chosen in this order:
  - `ctl_low_speed` = 1 gives 2 (subactive).
  - Otherwise `ctl_mid_speed` = 1 gives 1 (medium-speed).
  - Otherwise the target is 0 (high-speed).
- R2 (continued): A request whose controls are not all set, or whose target equals the current mode, has no effect. The stall stays low, no done pulse appears and the mode is unchanged.
- R3: Once a request is taken, the block counts 3 states on the tick of the current mode. Mode 0 uses `hs_tick`, mode 1 uses `ms_tick` and mode 2 uses `sub_tick`; ticks of the other clocks are not counted. At the edge of the third such tick, `mode_o` and `clk_sel_o` take the target code. Before that edge they hold their old value.
- R4: When the source mode is 2 and the target is 0 or 1, a settling wait follows the switch. It lasts a number of new-clock ticks set by `wait_sel`, which is sampled when the request is taken. The codes 0 to 7 give 8, 16, 32, 64, 256, 1024, 8192 and 16384 ticks.
- R5: When the source mode is 0 or 1, there is no settling wait. Exception counting starts at the switch.
- R6: Exception handling lasts 14 ticks of the new mode's clock. `done_o` is high for exactly one cycle, the cycle after the edge of the 14th tick.
- R7: `cpu_stall_o` is high from the cycle after the request is taken through the cycle in which the settling wait ends (or the switch, if there is no wait). It is low during exception handling.
- R8: A sleep request made while a transition is in progress is ignored, whatever the control inputs are. The transition's timing and its final mode are unchanged.
- R9: Take a transition from mode 1 to mode 0, with a medium-speed state of 16 cycles and a high-speed state of 2 cycles. With tick phases aligned at the request, `done_o` is seen 76 cycles after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock of the block; each cycle is one oscillator period |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req | input | 1 | Sleep request strobe from the CPU |
| ctl_standby | input | 1 | Standby-select control bit |
| ctl_low_speed | input | 1 | Selects subactive as target |
| ctl_mid_speed | input | 1 | Selects medium-speed active as target |
| ctl_direct | input | 1 | Enables direct transition |
| ctl_timer3 | input | 1 | Timer mode bit gating direct transition |
| wait_sel | input | 3 | Settling-wait length select |
| hs_tick | input | 1 | One high-speed system-clock state |
| ms_tick | input | 1 | One medium-speed system-clock state |
| sub_tick | input | 1 | One subclock state |
| mode_o | output | 2 | Current mode: 0 high-speed, 1 medium-speed, 2 subactive |
| clk_sel_o | output | 2 | Clock-select code, same encoding as the mode |
| cpu_stall_o | output | 1 | CPU stall during the sleep and settling phases |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
All outputs are registered, so a request taken at an edge raises the stall in the cycle that follows. The mode and clock-select codes move in the cycle after the edge that carries the third counted old-clock tick. The done pulse is visible in the cycle after the edge of the fourteenth new-clock tick.

The bench's behavioural model advances at the same edges as the design, and every output is compared in the middle of each cycle. Directed runs restart the tick phases at the request cycle. Each run then counts the cycles to done and the stalled cycles, and compares them with values worked out from the tick periods, such as 76 for the medium-to-high example and 16436 for the 8192-state wait.

// File: rtl/pwr_direct_pkg.sv
package pwr_direct_pkg;

   typedef enum logic [1:0] {
      MODE_HS  = 2'd0,
      MODE_MS  = 2'd1,
      MODE_SUB = 2'd2
   } pmode_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PRE  = 2'd1,
      PH_WAIT = 2'd2,
      PH_EXC  = 2'd3
   } phase_e;

endpackage

// File: rtl/pwr_direct_decode.sv
module pwr_direct_decode
   import pwr_direct_pkg::*;
(
   input  logic   ctl_standby,
   input  logic   ctl_low_speed,
   input  logic   ctl_mid_speed,
   input  logic   ctl_direct,
   input  logic   ctl_timer3,
   input  pmode_e cur_mode,
   output pmode_e tgt_mode,
   output logic   go
);

   always_comb begin
      if (ctl_low_speed)      tgt_mode = MODE_SUB;
      else if (ctl_mid_speed) tgt_mode = MODE_MS;
      else                    tgt_mode = MODE_HS;
   end

   assign go = ctl_standby & ctl_direct & ctl_timer3 & (tgt_mode != cur_mode);

endmodule

// File: rtl/pwr_direct_tick_sel.sv
module pwr_direct_tick_sel
   import pwr_direct_pkg::*;
(
   input  pmode_e mode,
   input  logic   hs_tick,
   input  logic   ms_tick,
   input  logic   sub_tick,
   output logic   tick
);

   always_comb begin
      case (mode)
         MODE_HS:  tick = hs_tick;
         MODE_MS:  tick = ms_tick;
         MODE_SUB: tick = sub_tick;
         default:  tick = 1'b0;
      endcase
   end

endmodule

// File: rtl/pwr_direct_count.sv
module pwr_direct_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   assign last = tick && (cnt_q == limit - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt_q <= '0;
      else if (tick)       cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < limit); // R3

endmodule

// File: rtl/pwr_direct_seq.sv
module pwr_direct_seq
   import pwr_direct_pkg::*;
#(
   parameter int          CNT_W       = 16,
   parameter int          PRE_STATES  = 3,
   parameter int          EXC_STATES  = 14,
   parameter int          SEL_W       = 3,
   parameter bit          WAIT_ALWAYS = 1'b0,
   parameter int unsigned WAIT_TABLE [2**SEL_W] =
      '{8, 16, 32, 64, 256, 1024, 8192, 16384}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             ctl_standby,
   input  logic             ctl_low_speed,
   input  logic             ctl_mid_speed,
   input  logic             ctl_direct,
   input  logic             ctl_timer3,
   input  logic [SEL_W-1:0] wait_sel,
   input  logic             hs_tick,
   input  logic             ms_tick,
   input  logic             sub_tick,
   output logic [1:0]       mode_o,
   output logic [1:0]       clk_sel_o,
   output logic             cpu_stall_o,
   output logic             done_o
);

   localparam int NUM_SEL = 2**SEL_W;
   localparam int CNT_MAX = 2**CNT_W - 1;

   // elaboration-time parameter checks
   if (PRE_STATES < 1 || PRE_STATES > CNT_MAX) begin : g_bad_pre
      $error("PRE_STATES out of range");
   end
   if (EXC_STATES < 1 || EXC_STATES > CNT_MAX) begin : g_bad_exc
      $error("EXC_STATES out of range");
   end
   for (genvar i = 0; i < NUM_SEL; i++) begin : g_tbl_chk
      if (WAIT_TABLE[i] < 1 || WAIT_TABLE[i] > CNT_MAX) begin : g_bad
         $error("WAIT_TABLE entry out of range");
      end
   end

   phase_e           phase_q;
   pmode_e           mode_q, tgt_q, dec_tgt;
   logic [1:0]       sel_q;
   logic [CNT_W-1:0] wait_q, limit;
   logic             done_q, dec_go, tick, last, need_wait;

   pwr_direct_decode u_dec (
      .ctl_standby  (ctl_standby),
      .ctl_low_speed(ctl_low_speed),
      .ctl_mid_speed(ctl_mid_speed),
      .ctl_direct   (ctl_direct),
      .ctl_timer3   (ctl_timer3),
      .cur_mode     (mode_q),
      .tgt_mode     (dec_tgt),
      .go           (dec_go)
   );

   pwr_direct_tick_sel u_tick (
      .mode    (mode_q),
      .hs_tick (hs_tick),
      .ms_tick (ms_tick),
      .sub_tick(sub_tick),
      .tick    (tick)
   );

   // variant: settling wait on every transition, or only when leaving subactive
   if (WAIT_ALWAYS) begin : g_wait_all
      assign need_wait = 1'b1;
   end else begin : g_wait_sub
      assign need_wait = (mode_q == MODE_SUB) && (dec_tgt != MODE_SUB);
   end

   always_comb begin
      case (phase_q)
         PH_PRE:  limit = CNT_W'(PRE_STATES);
         PH_WAIT: limit = wait_q;
         PH_EXC:  limit = CNT_W'(EXC_STATES);
         default: limit = CNT_W'(1);
      endcase
   end

   pwr_direct_count #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(phase_q == PH_IDLE),
      .tick (tick),
      .limit(limit),
      .last (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         mode_q  <= MODE_HS;
         tgt_q   <= MODE_HS;
         sel_q   <= 2'd0;
         wait_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: if (sleep_req && dec_go) begin
               phase_q <= PH_PRE;
               tgt_q   <= dec_tgt;
               wait_q  <= need_wait ? CNT_W'(WAIT_TABLE[wait_sel]) : '0;
            end
            PH_PRE: if (last) begin
               mode_q  <= tgt_q;
               sel_q   <= tgt_q;
               phase_q <= (wait_q != '0) ? PH_WAIT : PH_EXC;
            end
            PH_WAIT: if (last) phase_q <= PH_EXC;
            PH_EXC: if (last) begin
               phase_q <= PH_IDLE;
               done_q  <= 1'b1;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign mode_o      = mode_q;
   assign clk_sel_o   = sel_q;
   assign cpu_stall_o = (phase_q == PH_PRE) || (phase_q == PH_WAIT);
   assign done_o      = done_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R6
   AST_DONE_AFTER_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(phase_q) == PH_EXC); // R6
   AST_MODE_AT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> $past(phase_q) == PH_PRE); // R3
   AST_NO_RETARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) && sleep_req |=> $stable(tgt_q)); // R8
   if (!WAIT_ALWAYS) begin : g_wait_ast
      AST_WAIT_FROM_SUB: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(phase_q == PH_WAIT) |-> $past(mode_q) == MODE_SUB); // R4
   end

endmodule

// File: tb/pwr_direct_seq_test.sv
`timescale 1ns/1ps
module pwr_direct_seq_test;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, sleep_req, ctl_standby, ctl_low_speed, ctl_mid_speed;
   logic       ctl_direct, ctl_timer3, hs_tick, ms_tick, sub_tick;
   logic [2:0] wait_sel;
   logic [1:0] mode_o, clk_sel_o;
   logic       cpu_stall_o, done_o;

   pwr_direct_seq uut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
      .ctl_standby(ctl_standby), .ctl_low_speed(ctl_low_speed),
      .ctl_mid_speed(ctl_mid_speed), .ctl_direct(ctl_direct),
      .ctl_timer3(ctl_timer3), .wait_sel(wait_sel),
      .hs_tick(hs_tick), .ms_tick(ms_tick), .sub_tick(sub_tick),
      .mode_o(mode_o), .clk_sel_o(clk_sel_o),
      .cpu_stall_o(cpu_stall_o), .done_o(done_o)
   );

   int checks = 0, errors = 0;
   int n = 0;
   int hs_div = 2, ms_div = 16, sub_div = 8;
   bit cmp_en = 0;

   function automatic void chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endfunction

   function automatic int wait_len(int code);
      case (code)
         0: return 8;     1: return 16;   2: return 32;   3: return 64;
         4: return 256;   5: return 1024; 6: return 8192; default: return 16384;
      endcase
   endfunction

   // behavioural reference model
   int m_mode = 0, m_phase = 0, m_rem = 0, m_tgt = 0, m_wait = 0;
   bit m_stall = 0, m_done = 0;

   always @(posedge clk) begin
      bit t;
      int tg;
      t = (m_mode == 0) ? hs_tick : (m_mode == 1) ? ms_tick : sub_tick;
      m_done = 0;
      if (!rst_n) begin
         m_mode = 0; m_phase = 0; m_rem = 0; m_stall = 0;
      end else begin
         case (m_phase)
            0: if (sleep_req && ctl_standby && ctl_direct && ctl_timer3) begin
               tg = ctl_low_speed ? 2 : (ctl_mid_speed ? 1 : 0);
               if (tg != m_mode) begin
                  m_tgt = tg; m_phase = 1; m_rem = 3; m_stall = 1;
                  m_wait = (m_mode == 2) ? wait_len(int'(wait_sel)) : 0;
               end
            end
            1: if (t) begin
               m_rem--;
               if (m_rem == 0) begin
                  m_mode = m_tgt;
                  if (m_wait > 0) begin m_phase = 2; m_rem = m_wait; end
                  else begin m_phase = 3; m_rem = 14; m_stall = 0; end
               end
            end
            2: if (t) begin
               m_rem--;
               if (m_rem == 0) begin m_phase = 3; m_rem = 14; m_stall = 0; end
            end
            default: if (t) begin
               m_rem--;
               if (m_rem == 0) begin m_phase = 0; m_done = 1; end
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         chk(mode_o == 2'(m_mode), "R3 mode_o vs model", int'(mode_o), m_mode);
         chk(clk_sel_o == 2'(m_mode), "R3 clk_sel_o vs model", int'(clk_sel_o), m_mode);
         chk(cpu_stall_o == m_stall, "R7 cpu_stall_o vs model", int'(cpu_stall_o), int'(m_stall));
         chk(done_o == m_done, "R6 done_o vs model", int'(done_o), int'(m_done));
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 190000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic drive_ticks();
      hs_tick  = (n % hs_div)  == hs_div - 1;
      ms_tick  = (n % ms_div)  == ms_div - 1;
      sub_tick = (n % sub_div) == sub_div - 1;
   endtask

   task automatic step();
      @(negedge clk);
      n++;
      drive_ticks();
   endtask

   task automatic transit(bit low, bit mid, logic [2:0] ws, int exp_n, int exp_stall,
                          int exp_mode, bit poke, string tag);
      int got = -1, stalls = 0;
      step();
      n = 0; drive_ticks();
      ctl_standby = 1; ctl_direct = 1; ctl_timer3 = 1;
      ctl_low_speed = low; ctl_mid_speed = mid; wait_sel = ws; sleep_req = 1;
      step();
      sleep_req = 0;
      while (n <= exp_n + 20 && !(got >= 0 && n > got + 2)) begin
         if (done_o && got < 0) got = n;
         if (cpu_stall_o) stalls++;
         if (poke && n == 4) begin
            sleep_req = 1; ctl_low_speed = 0; ctl_mid_speed = ~mid; wait_sel = 3'd7;
         end else if (poke && n == 5) begin
            sleep_req = 0; ctl_low_speed = low; ctl_mid_speed = mid;
         end
         step();
      end
      chk(got == exp_n, {tag, " cycles to done"}, got, exp_n);
      chk(stalls == exp_stall, {tag, " stalled cycles (R7)"}, stalls, exp_stall);
      chk(int'(mode_o) == exp_mode, {tag, " final mode"}, int'(mode_o), exp_mode);
   endtask

   task automatic ignored(bit std, bit dir, bit tm3, bit low, bit mid, int exp_mode, string tag);
      int stalls = 0, dones = 0;
      step();
      ctl_standby = std; ctl_direct = dir; ctl_timer3 = tm3;
      ctl_low_speed = low; ctl_mid_speed = mid; sleep_req = 1;
      step();
      sleep_req = 0;
      for (int i = 0; i < 300; i++) begin
         if (cpu_stall_o) stalls++;
         if (done_o) dones++;
         step();
      end
      chk(stalls == 0, {tag, " stall cycles"}, stalls, 0);
      chk(dones == 0, {tag, " done pulses"}, dones, 0);
      chk(int'(mode_o) == exp_mode, {tag, " mode"}, int'(mode_o), exp_mode);
   endtask

   initial begin
      rst_n = 0; sleep_req = 0; ctl_standby = 0; ctl_low_speed = 0;
      ctl_mid_speed = 0; ctl_direct = 0; ctl_timer3 = 0; wait_sel = 3'd0;
      hs_tick = 0; ms_tick = 0; sub_tick = 0;
      repeat (3) step();
      // R1 reset state
      chk(mode_o == 2'd0, "R1 mode_o after reset", int'(mode_o), 0);
      chk(clk_sel_o == 2'd0, "R1 clk_sel_o after reset", int'(clk_sel_o), 0);
      chk(cpu_stall_o == 1'b0, "R1 cpu_stall_o after reset", int'(cpu_stall_o), 0);
      chk(done_o == 1'b0, "R1 done_o after reset", int'(done_o), 0);
      rst_n = 1;
      cmp_en = 1;
      // R5 high-speed to medium-speed, no wait
      transit(0, 1, 3'd0, 224, 5, 1, 0, "R5 hs->ms");
      // R9 medium-speed to high-speed example
      transit(0, 0, 3'd0, 76, 47, 0, 0, "R9 ms->hs");
      // R5 high-speed to subactive
      transit(1, 0, 3'd0, 112, 5, 2, 0, "R5 hs->sub");
      // R4 subactive to high-speed, code 0 = 8 states
      transit(0, 0, 3'd0, 68, 39, 0, 0, "R4 sub->hs wait8");
      // R8 second request during transition ignored
      transit(1, 0, 3'd0, 112, 5, 2, 1, "R8 hs->sub poked");
      // R4 code 6 = 8192 states
      transit(0, 0, 3'd6, 16436, 16407, 0, 0, "R4 sub->hs wait8192");
      transit(1, 0, 3'd0, 112, 5, 2, 0, "R3 hs->sub");
      // R4 subactive to medium-speed, code 3 = 64 states
      transit(0, 1, 3'd3, 1264, 1039, 1, 0, "R4 sub->ms wait64");
      // R2 requests that must have no effect (current mode 1)
      ignored(1, 0, 1, 0, 0, 1, "R2 direct off");
      ignored(1, 1, 0, 0, 0, 1, "R2 timer3 off");
      ignored(0, 1, 1, 0, 0, 1, "R2 standby off");
      ignored(1, 1, 1, 0, 1, 1, "R2 target equals current");
      step();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule